// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block keeps a free-running 64-bit time base and three one-shot alarm channels. The time base advances by one on each cycle where the reference tick pulse `tick_en` is high and the global run bit is set. Software reads the whole count in a single access. Because the full 64-bit value is returned at once, a carry between its halves can never appear half-applied.

Each channel holds a target value. Writing a target arms the channel. On an advancing tick, an armed channel whose target equals the count sets a sticky pending flag and disarms itself. The channel's interrupt line follows its pending flag until software clears the flag by writing a one to its bit. A target that the count has already passed produces no interrupt.

The register port is a flat 64-bit, single-cycle write port with a combinational read path. The register map is:

| Address | Register |
|---|---|
| 0 | Control; bit 0 is the run bit |
| 1 | Count, read only |
| 2 | Pending flags; bit i belongs to channel i; write ones to clear |
| 3 + i | Target of channel i |

Top module: `evt_timer`

## Requirements
- R1: After a synchronous active-low reset, the count, the control register, all targets, all pending flags and `irq` read as zero, and every channel is disarmed.
- R2: The count rises by exactly one at each clock edge where `tick_en` is 1 and the run bit (control bit 0) is 1. Otherwise the count holds its value.
- R3: `rdata` shows the register selected by `addr` in the same cycle. Address 1 returns all 64 bits of the count, address 0 returns the run bit in bit 0 with zeros above, and unmapped addresses return zero.
- R4: A write to address 3+i stores `wdata` as channel i's target and arms the channel. Reading the same address returns that target.
- R5: An armed channel whose target equals the count at an advancing tick edge sets its pending flag at that edge. This is the edge that moves the count from target to target+1. The same edge disarms the channel, and `irq[i]` is high from then on.
- R6: After a channel fires and its flag is cleared, it raises no further interrupt until its target is written again.
- R7: If a target is written equal to the current count, the channel fires on the next advancing tick. If a target is written below the current count, the channel never fires while the count keeps rising.
- R8: A pending flag stays set until a write to address 2 with bit i set. Bits written as zero leave their flags unchanged. `irq[i]` equals pending bit i, and address 2 returns the flags in bits 2:0.
- R9: While the run bit is 0, ticks neither advance the count nor fire any channel.
- R10: Channels are independent. Channels with equal targets fire on the same edge, and channels with different targets fire at their own ticks.
- R11: If a target write and a matching tick fall on the same edge, the write wins. The channel is re-armed with the new target and does not fire on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Reference tick pulse, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr`, combinational |
| irq | output | 3 | Interrupt per channel; mirrors the pending flags |

## Verification
The bench places targets exactly at the current count and below it. A design that matched on the incremented count would miss the first case. A design that used a greater-or-equal compare would fire wrongly on the second. The bench checks that an interrupt appears exactly one tick after the count reaches the target, not one tick early or late. It confirms that ticks with the run bit clear advance nothing and fire nothing. It clears pending flags selectively, to catch a clear that wipes every flag or that clears a bit written as zero. It also places a target write and a match on the same edge, which exposes a design that lets the stale match win.

// File: rtl/tmr_pkg.sv
// Shared constants of the event timer: the register address map.
// Assumes the comparator targets occupy consecutive addresses from CMP_BASE.
package tmr_pkg;
    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_CNT  = 1;
    localparam int unsigned ADDR_PEND = 2;
    localparam int unsigned CMP_BASE  = 3;
endpackage

// File: rtl/tmr_counter.sv
// Free-running time base. It advances by one when run and tick_en are both high.
// Assumes tick_en is a one-cycle pulse per reference tick, synchronous to clk.
module tmr_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    output logic             adv,
    output logic [CNT_W-1:0] cnt
);
    // Qualify the tick with the run bit.
    assign adv = run & tick_en;

    // Count register: clears in reset and steps by one on each advancing tick.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (cnt == $past(cnt) + 1'b1));
    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt));
endmodule

// File: rtl/tmr_chan.sv
// One-shot comparator channel. A target write arms the channel. On an
// advancing tick whose pre-increment count equals the target, the channel
// sets its sticky pending flag and disarms. A write on the same edge
// overrides the match. If a set and a clear of the flag fall on the same
// edge, the set wins.
// Assumes cnt and adv come from the shared time base.
module tmr_chan #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr_tgt,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] tgt,
    output logic             pend
);
    logic armed;
    logic hit;

    // Match qualifier: armed, advancing, equal, and not overridden by a write.
    assign hit = armed & adv & (cnt == tgt) & ~wr_tgt;

    // Target and arm state: a write loads and arms, and a hit disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt   <= '0;
            armed <= 1'b0;
        end else if (wr_tgt) begin
            tgt   <= wdata;
            armed <= 1'b1;
        end else if (hit) begin
            armed <= 1'b0;
        end
    end

    // Pending flag: a hit sets it, a clear drops it, and a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (hit) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

    // R5
    fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && adv && (cnt == tgt) && !wr_tgt) |=> (pend && !armed));
    // R6
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !wr_tgt) |=> !armed);
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);
    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tgt |=> (armed && tgt == $past(wdata)));
endmodule

// File: rtl/evt_timer.sv
// Event timer top: the shared time base, NCH one-shot comparator channels,
// the write decode and the combinational read mux.
// Assumes 3+NCH addresses fit in ADDR_W bits and the data width equals CNT_W.
module evt_timer #(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned NCH    = 3,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NCH-1:0]    irq
);
    import tmr_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADDR_CNT);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ADDR_PEND);

    logic             run;
    logic             adv;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tgt [NCH];
    logic [NCH-1:0]   pend;

    // Control register: holds the global run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                         run <= 1'b0;
        else if (wr_en && addr == A_CTRL)   run <= wdata[0];
    end

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick_en (tick_en),
        .adv     (adv),
        .cnt     (cnt)
    );

    // One channel per comparator, each with its own write and clear decode.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_chan #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (adv),
            .cnt    (cnt),
            .wr_tgt (wr_en && addr == ADDR_W'(CMP_BASE + i)),
            .wdata  (wdata),
            .clr    (wr_en && addr == A_PEND && wdata[i]),
            .tgt    (tgt[i]),
            .pend   (pend[i])
        );
    end

    assign irq = pend;

    // Read mux: selects the addressed register, and returns zero when unmapped.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)      rdata[0] = run;
        else if (addr == A_CNT)  rdata = cnt;
        else if (addr == A_PEND) rdata[NCH-1:0] = pend;
        for (int i = 0; i < NCH; i++)
            if (addr == ADDR_W'(CMP_BASE + i)) rdata = tgt[i];
    end

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PEND && wdata[0] && !adv) |=> !irq[0]);
endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [2:0]  irq;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] ecnt = '0;

    always #5 clk = ~clk;

    evt_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [63:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Ticks n edges; ecnt follows only when the run bit is expected set.
    task automatic tick(input int n, input bit running);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        if (running) ecnt = ecnt + 64'(n);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 6; a++) rd(4'(a), 64'd0, "R1 reset register");
        rd(4'd9, 64'd0, "R3 unmapped address");
        chk("R1 reset irq", 64'(irq), 64'd0);
    endtask

    task automatic t_count;
        tick(3, 1'b0);
        rd(4'd1, 64'd0, "R9 no count while stopped");
        wr(4'd0, 64'd1);
        rd(4'd0, 64'd1, "R3 control readback");
        tick(5, 1'b1);
        rd(4'd1, ecnt, "R2 count after five ticks");
        repeat (4) @(negedge clk);
        rd(4'd1, ecnt, "R2 hold without tick");
        tick(1, 1'b1);
        rd(4'd1, ecnt, "R3 full count read");
    endtask

    task automatic t_fire;
        wr(4'd3, ecnt + 3);
        rd(4'd3, ecnt + 3, "R4 target readback");
        tick(3, 1'b1);
        chk("R5 no early fire", 64'(irq), 64'd0);
        tick(1, 1'b1);
        chk("R5 fire one tick after reaching target", 64'(irq), 64'd1);
        rd(4'd2, 64'd1, "R8 pending readback");
        tick(5, 1'b1);
        chk("R8 pending sticky", 64'(irq), 64'd1);
        wr(4'd2, 64'd0);
        chk("R8 zero write keeps flag", 64'(irq), 64'd1);
        wr(4'd2, 64'd1);
        chk("R8 clear", 64'(irq), 64'd0);
        tick(6, 1'b1);
        chk("R6 no refire", 64'(irq), 64'd0);
    endtask

    task automatic t_past;
        wr(4'd4, ecnt - 2);
        tick(10, 1'b1);
        chk("R7 past target silent", 64'(irq), 64'd0);
        wr(4'd4, ecnt);
        chk("R7 no fire before tick", 64'(irq), 64'd0);
        tick(1, 1'b1);
        chk("R7 equal target fires next tick", 64'(irq), 64'd2);
        wr(4'd2, 64'd7);
    endtask

    task automatic t_indep;
        wr(4'd3, ecnt + 2);
        wr(4'd5, ecnt + 2);
        wr(4'd4, ecnt + 4);
        tick(3, 1'b1);
        chk("R10 equal targets fire together", 64'(irq), 64'd5);
        tick(2, 1'b1);
        chk("R10 later channel fires", 64'(irq), 64'd7);
        wr(4'd2, 64'd2);
        chk("R8 selective clear", 64'(irq), 64'd5);
        wr(4'd2, 64'd7);
        chk("R8 clear all", 64'(irq), 64'd0);
    endtask

    task automatic t_stop;
        wr(4'd3, ecnt);
        wr(4'd0, 64'd0);
        tick(4, 1'b0);
        chk("R9 no fire while stopped", 64'(irq), 64'd0);
        rd(4'd1, ecnt, "R9 count frozen");
        wr(4'd0, 64'd1);
        tick(1, 1'b1);
        chk("R9 fires after restart", 64'(irq), 64'd1);
        wr(4'd2, 64'd7);
    endtask

    task automatic t_wrwin;
        wr(4'd5, ecnt);
        tick_en = 1'b1; wr_en = 1'b1; addr = 4'd5; wdata = ecnt + 3;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        ecnt = ecnt + 1;
        chk("R11 write beats match", 64'(irq), 64'd0);
        rd(4'd5, ecnt + 2, "R11 new target kept");
        tick(2, 1'b1);
        chk("R11 no fire at new target yet", 64'(irq), 64'd0);
        tick(1, 1'b1);
        chk("R11 fires at new target", 64'(irq), 64'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_fire();
        t_past();
        t_indep();
        t_stop();
        t_wrwin();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule